// File: doc/BRIEF.md
# Sound Chip Command/Data Bridge

This block sits between a CPU's register bus and a sound generator chip that has a multiplexed address/data bus. The CPU sees two registers: a command register and a data port. The data port's address does not decide what happens to the chip. The code stored in the command register decides it. Depending on that code, a data port access does one of four things: it does nothing, it reads the chip's data register, it writes the chip's data register, or it latches a chip register address and sends it to the chip as an address-phase write.

An elaboration parameter selects one of two variants. In the basic variant the command register holds a 2-bit code. In the extended variant it holds 4 bits. Bit 3 turns data reads into reads of an external joystick/port input. Bit 2 turns data reads into reads of the chip's status register. These override bits take precedence over the 2-bit code, and bit 3 wins over bit 2. Accesses on the chip side are single-cycle strobes. Each strobe comes with a separate address-select line and a read/not-write line. Read results reach the CPU in the same cycle as the access.

Top module: `sgb_bridge`

## Requirements
- R1: After reset the command register holds 0 (idle). Command readback is 0xF0 in the extended variant and 0xFC in the basic variant.
- R2: Command readback places the stored command bits in the low bits. Every bit above them reads 1: bits 7..4 in the extended variant, bits 7..2 in the basic variant.
- R3: With code 2 (low two command bits = 2'b10), a data port write pulses snd_stb for that cycle with snd_rnw=0 and snd_asel=0. It also drives the written byte on snd_wdata.
- R4: With code 3 (2'b11), a data port write pulses snd_stb with snd_rnw=0 and snd_asel=1. It drives the low 4 bits of the byte, zero-extended, on snd_wdata, and stores those 4 bits as the latched register address from the next cycle on.
- R5: With code 0 (2'b00) or code 1 (2'b01), a data port write produces no strobe.
- R6: With code 1, a data port read pulses snd_stb with snd_rnw=1 and snd_asel=0, and returns snd_rdata to the CPU.
- R7: With code 2, a data port read returns the conflict value 0xFF and produces no strobe.
- R8: With code 0, a data port read returns 0xFF without a strobe. With code 3, a data port read returns the latched register address in bits 3..0 and zeros above, without a strobe.
- R9: Extended variant, command bit 2 set and bit 3 clear: a data port read pulses snd_stb with snd_rnw=1 and snd_asel=1, and returns snd_status.
- R10: Extended variant, command bit 3 set: a data port read returns joy_in and produces no strobe, whatever bit 2 and the 2-bit code hold.
- R11: Extended variant, command bit 2 or bit 3 set: a data port write produces no strobe and leaves the latched register address unchanged.
- R12: Basic variant: command bits 7..2 of a write are ignored, so only the 2-bit code governs data port accesses.
- R13: Accesses to the command register never strobe the chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | CPU access to this block in this cycle |
| bus_sel | input | 1 | Register select: 0 command register, 1 data port |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_wdata | input | DATA_W | CPU write data |
| bus_rdata | output | DATA_W | CPU read data, valid in the cycle of the read |
| snd_stb | output | 1 | One-cycle access strobe to the sound chip |
| snd_asel | output | 1 | 1 selects the chip's address/status side, 0 its data register |
| snd_rnw | output | 1 | 1 read, 0 write |
| snd_wdata | output | DATA_W | Data or address byte sent to the chip |
| snd_rdata | input | DATA_W | Chip data register contents |
| snd_status | input | DATA_W | Chip status register contents |
| joy_in | input | DATA_W | Joystick/port input value |

## Verification
The hardest state to reach is an extended-variant command that has an override bit set over a 2-bit code that would otherwise write. In that state a data write must leave the latched address alone. That effect shows only later, through a code-3 read after the command is changed back. The stimulus loads command 0xF, writes a new byte to the data port, switches to code 3 and reads. A basic instance runs next to the extended one on the same inputs. The same write changes the basic instance's latch, so the two readbacks must differ.

// File: rtl/sgb_pkg.sv
package sgb_pkg;

   typedef enum logic [1:0] {
      CODE_IDLE  = 2'd0,
      CODE_RDATA = 2'd1,
      CODE_WDATA = 2'd2,
      CODE_ADDR  = 2'd3
   } sgb_code_e;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_RD_DATA,
      ACT_RD_STAT,
      ACT_RD_JOY,
      ACT_CONFLICT,
      ACT_ADDR_BACK,
      ACT_WR_DATA,
      ACT_WR_ADDR
   } sgb_act_e;

endpackage

// File: rtl/sgb_cmd_reg.sv
module sgb_cmd_reg #(
   parameter int CMD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CMD_W-1:0] wr_val,
   output logic [CMD_W-1:0] cmd_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cmd_q <= '0;
      else if (wr_en)
         cmd_q <= wr_val;
   end

   // R2
   cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cmd_q == $past(wr_val));

endmodule

// File: rtl/sgb_decode.sv
module sgb_decode
   import sgb_pkg::*;
#(
   parameter int CMD_W    = 4,
   parameter bit EXTENDED = 1'b1
) (
   input  logic [CMD_W-1:0] cmd,
   input  logic             data_wr,
   input  logic             data_rd,
   output sgb_act_e         act
);

   logic      ovr_joy;
   logic      ovr_stat;
   sgb_code_e code;

   assign code = sgb_code_e'(cmd[1:0]);

   generate
      if (EXTENDED) begin : g_ext
         assign ovr_joy  = cmd[3];
         assign ovr_stat = cmd[2];
      end else begin : g_basic
         assign ovr_joy  = 1'b0;
         assign ovr_stat = 1'b0;
      end
   endgenerate

   always_comb begin
      act = ACT_NONE;
      if (data_wr) begin
         if (!(ovr_joy || ovr_stat)) begin
            case (code)
               CODE_WDATA: act = ACT_WR_DATA;
               CODE_ADDR:  act = ACT_WR_ADDR;
               default:    act = ACT_NONE;
            endcase
         end
      end else if (data_rd) begin
         if (ovr_joy)
            act = ACT_RD_JOY;
         else if (ovr_stat)
            act = ACT_RD_STAT;
         else begin
            case (code)
               CODE_RDATA: act = ACT_RD_DATA;
               CODE_WDATA: act = ACT_CONFLICT;
               CODE_ADDR:  act = ACT_ADDR_BACK;
               default:    act = ACT_NONE;
            endcase
         end
      end
   end

endmodule

// File: rtl/sgb_datapath.sv
module sgb_datapath
   import sgb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sgb_act_e          act,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] snd_rdata,
   input  logic [DATA_W-1:0] snd_status,
   input  logic [DATA_W-1:0] joy_in,
   output logic [DATA_W-1:0] rd_val,
   output logic              snd_stb,
   output logic              snd_asel,
   output logic              snd_rnw,
   output logic [DATA_W-1:0] snd_wdata
);

   localparam int PAD_W = DATA_W - ADDR_W;

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] addr_ext;

   assign addr_ext = {{PAD_W{1'b0}}, addr_q};

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= '0;
      else if (act == ACT_WR_ADDR)
         addr_q <= bus_wdata[ADDR_W-1:0];
   end

   always_comb begin
      snd_stb   = 1'b0;
      snd_asel  = 1'b0;
      snd_rnw   = 1'b1;
      snd_wdata = bus_wdata;
      rd_val    = '1;
      case (act)
         ACT_RD_DATA: begin
            snd_stb = 1'b1;
            rd_val  = snd_rdata;
         end
         ACT_RD_STAT: begin
            snd_stb  = 1'b1;
            snd_asel = 1'b1;
            rd_val   = snd_status;
         end
         ACT_RD_JOY:    rd_val = joy_in;
         ACT_ADDR_BACK: rd_val = addr_ext;
         ACT_WR_DATA: begin
            snd_stb = 1'b1;
            snd_rnw = 1'b0;
         end
         ACT_WR_ADDR: begin
            snd_stb   = 1'b1;
            snd_asel  = 1'b1;
            snd_rnw   = 1'b0;
            snd_wdata = {{PAD_W{1'b0}}, bus_wdata[ADDR_W-1:0]};
         end
         default: ;
      endcase
   end

   // R4
   addr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_WR_ADDR) |=> addr_q == $past(bus_wdata[ADDR_W-1:0]));

   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act != ACT_WR_ADDR) |=> $stable(addr_q));

endmodule

// File: rtl/sgb_bridge.sv
module sgb_bridge
   import sgb_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 4,
   parameter bit EXTENDED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              snd_stb,
   output logic              snd_asel,
   output logic              snd_rnw,
   output logic [DATA_W-1:0] snd_wdata,
   input  logic [DATA_W-1:0] snd_rdata,
   input  logic [DATA_W-1:0] snd_status,
   input  logic [DATA_W-1:0] joy_in
);

   localparam int CMD_W  = EXTENDED ? 4 : 2;
   localparam int FILL_W = DATA_W - CMD_W;

   generate
      if (DATA_W < CMD_W + 1) begin : g_bad_dw
         $error("DATA_W too narrow for command readback");
      end
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_aw
         $error("ADDR_W must lie in 1..DATA_W");
      end
   endgenerate

   logic             cmd_wr;
   logic             data_wr;
   logic             data_rd;
   logic [CMD_W-1:0] cmd_q;
   logic [DATA_W-1:0] data_val;
   sgb_act_e         act;

   assign cmd_wr  = bus_cs && !bus_sel && bus_wr;
   assign data_wr = bus_cs &&  bus_sel && bus_wr;
   assign data_rd = bus_cs &&  bus_sel && bus_rd;

   sgb_cmd_reg #(.CMD_W(CMD_W)) cmd_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cmd_wr),
      .wr_val (bus_wdata[CMD_W-1:0]),
      .cmd_q  (cmd_q)
   );

   sgb_decode #(.CMD_W(CMD_W), .EXTENDED(EXTENDED)) dec_i (
      .cmd     (cmd_q),
      .data_wr (data_wr),
      .data_rd (data_rd),
      .act     (act)
   );

   sgb_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (act),
      .bus_wdata  (bus_wdata),
      .snd_rdata  (snd_rdata),
      .snd_status (snd_status),
      .joy_in     (joy_in),
      .rd_val     (data_val),
      .snd_stb    (snd_stb),
      .snd_asel   (snd_asel),
      .snd_rnw    (snd_rnw),
      .snd_wdata  (snd_wdata)
   );

   assign bus_rdata = bus_sel ? data_val : {{FILL_W{1'b1}}, cmd_q};

   // R13
   stb_data_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snd_stb |-> (bus_cs && bus_sel));

   // R6
   rd_stb_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_stb && bus_rd && !bus_wr) |-> snd_rnw);

   // R3
   wr_stb_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_stb && bus_wr) |-> !snd_rnw);

   // R5
   idle_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && cmd_q[1] == 1'b0) |-> !snd_stb);

endmodule

// File: tb/sgb_bridge_tb_top.sv
module sgb_bridge_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_cs = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] snd_rdata = 8'h3C, snd_status = 8'hA5, joy_in = 8'h42;
   logic [7:0] e_rdata, b_rdata, e_wdata, b_wdata;
   logic       e_stb, e_asel, e_rnw, b_stb, b_asel, b_rnw;
   int         total = 0;
   int         bad = 0;

   always #2 clk = ~clk;

   sgb_bridge #(.EXTENDED(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(e_rdata), .snd_stb(e_stb), .snd_asel(e_asel),
      .snd_rnw(e_rnw), .snd_wdata(e_wdata), .snd_rdata(snd_rdata),
      .snd_status(snd_status), .joy_in(joy_in));

   sgb_bridge #(.EXTENDED(1'b0)) dut_b (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(b_rdata), .snd_stb(b_stb), .snd_asel(b_asel),
      .snd_rnw(b_rnw), .snd_wdata(b_wdata), .snd_rdata(snd_rdata),
      .snd_status(snd_status), .joy_in(joy_in));

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // drive one access at the falling edge, sample 1 ns later, let the rising edge commit it
   task automatic access(input logic sel, input logic wr, input logic [7:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_sel = sel; bus_wr = wr; bus_rd = !wr; bus_wdata = d;
      #1;
   endtask

   task automatic release_bus();
      @(posedge clk);
      @(negedge clk);
      bus_cs = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_sel = 1'b0;
   endtask

   task automatic set_cmd(input logic [7:0] v);
      access(1'b0, 1'b1, v);
      chk("R13", "ext stb on cmd write", {7'd0, e_stb}, 8'h00);
      chk("R13", "basic stb on cmd write", {7'd0, b_stb}, 8'h00);
      release_bus();
   endtask

   task automatic t_reset();
      access(1'b0, 1'b0, 8'h00);
      chk("R1", "ext cmd readback", e_rdata, 8'hF0);
      chk("R1", "basic cmd readback", b_rdata, 8'hFC);
      chk("R13", "stb on cmd read", {6'd0, e_stb, b_stb}, 8'h00);
      release_bus();
   endtask

   task automatic t_write_data();
      set_cmd(8'h02);
      access(1'b1, 1'b1, 8'h5A);
      chk("R3", "ext stb/asel/rnw", {5'd0, e_stb, e_asel, e_rnw}, 8'h04);
      chk("R3", "basic stb/asel/rnw", {5'd0, b_stb, b_asel, b_rnw}, 8'h04);
      chk("R3", "ext wdata", e_wdata, 8'h5A);
      release_bus();
      access(1'b1, 1'b0, 8'h00);
      chk("R7", "ext conflict read", e_rdata, 8'hFF);
      chk("R7", "basic stb on conflict", {6'd0, e_stb, b_stb}, 8'h00);
      release_bus();
   endtask

   task automatic t_addr();
      set_cmd(8'h03);
      access(1'b1, 1'b1, 8'hB7);
      chk("R4", "ext stb/asel/rnw", {5'd0, e_stb, e_asel, e_rnw}, 8'h06);
      chk("R4", "basic wdata", b_wdata, 8'h07);
      release_bus();
      access(1'b1, 1'b0, 8'h00);
      chk("R8", "ext addr readback", e_rdata, 8'h07);
      chk("R8", "basic addr readback", b_rdata, 8'h07);
      chk("R8", "stb on addr readback", {6'd0, e_stb, b_stb}, 8'h00);
      release_bus();
   endtask

   task automatic t_idle_and_read();
      set_cmd(8'h00);
      access(1'b1, 1'b1, 8'h11);
      chk("R5", "stb on idle write", {6'd0, e_stb, b_stb}, 8'h00);
      release_bus();
      access(1'b1, 1'b0, 8'h00);
      chk("R8", "idle read value", b_rdata, 8'hFF);
      chk("R8", "stb on idle read", {6'd0, e_stb, b_stb}, 8'h00);
      release_bus();
      set_cmd(8'h01);
      access(1'b1, 1'b0, 8'h00);
      chk("R6", "ext stb/asel/rnw", {5'd0, e_stb, e_asel, e_rnw}, 8'h05);
      chk("R6", "basic read value", b_rdata, 8'h3C);
      release_bus();
      access(1'b1, 1'b1, 8'h22);
      chk("R5", "stb on code1 write", {6'd0, e_stb, b_stb}, 8'h00);
      release_bus();
   endtask

   task automatic t_status_override();
      set_cmd(8'hF6);
      access(1'b0, 1'b0, 8'h00);
      chk("R2", "ext cmd readback", e_rdata, 8'hF6);
      chk("R12", "basic cmd readback", b_rdata, 8'hFE);
      release_bus();
      access(1'b1, 1'b0, 8'h00);
      chk("R9", "ext status stb/asel/rnw", {5'd0, e_stb, e_asel, e_rnw}, 8'h07);
      chk("R9", "ext status value", e_rdata, 8'hA5);
      chk("R12", "basic conflict read", {b_rdata[7:1], b_stb}, 8'hFE);
      release_bus();
      access(1'b1, 1'b1, 8'h99);
      chk("R11", "ext stb on overridden write", {7'd0, e_stb}, 8'h00);
      chk("R12", "basic write stb/rnw", {6'd0, b_stb, b_rnw}, 8'h02);
      release_bus();
   endtask

   task automatic t_joy_override();
      set_cmd(8'h0F);
      access(1'b1, 1'b0, 8'h00);
      chk("R10", "ext joy value", e_rdata, 8'h42);
      chk("R10", "ext stb on joy read", {7'd0, e_stb}, 8'h00);
      chk("R12", "basic code3 readback", b_rdata, 8'h07);
      release_bus();
      access(1'b1, 1'b1, 8'h1E);
      chk("R11", "ext stb on joy-mode write", {7'd0, e_stb}, 8'h00);
      chk("R12", "basic addr write wdata", b_wdata, 8'h0E);
      release_bus();
      set_cmd(8'h03);
      access(1'b1, 1'b0, 8'h00);
      chk("R11", "ext latch kept", e_rdata, 8'h07);
      chk("R4", "basic latch updated", b_rdata, 8'h0E);
      release_bus();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_data();
      t_addr();
      t_idle_and_read();
      t_status_override();
      t_joy_override();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule